// File: doc/BRIEF.md
# Host Port Interface Slave

This block lets an external host read and write a 32-bit word memory that sits inside the block, through a 16-bit parallel port on which the host is always the master. The host reaches three registers: a control register, an address register that holds the word address of the current memory access, and a data register that stands for the memory word at that address. A 2-bit select input picks the register for each access, and a read/write line sets the direction. Every 32-bit word crosses the port as two consecutive 16-bit halfword cycles. A control bit sets whether the first halfword of a pair is the upper or the lower half of the word.

An access is a single-cycle strobe that the block accepts only while its ready output is high. A data read fetches the memory word on the first halfword and drops ready until the word is available. A data write stores the first halfword and writes memory when the second halfword arrives. One select code advances the address register by one word after each completed data pair, so the host can stream a block without reloading the address. Hosts with a multiplexed bus drive an active-low address strobe, and the select and halfword inputs are captured on its falling edge. A control bit toggles an interrupt line to the host.

Top module: `hpi_host_port`

## Requirements
- R1: After synchronous reset, ready is 1, the interrupt is 0, read data is 0, and the control register reads 0.
- R2: A control write on the first halfword (halfword input 0) loads the order bit from data bit 0. A control read returns the order bit in bit 0 and the interrupt state in bit 1, all other bits 0, on the cycle after the strobe.
- R3: A first-halfword control write with data bit 1 set toggles the interrupt output. A write with bit 1 clear, the second halfword of a control write, and every other access leave the interrupt unchanged.
- R4: The address register is loaded by the lower-half cycle of an address write. A read of the lower half returns the address zero-extended and a read of the upper half returns 0. The lower half is the second halfword (halfword input 1) when the order bit is 1 and the first halfword when it is 0.
- R5: A data write changes memory only on the second halfword. After only the first halfword, the stored word is unchanged.
- R6: A first-halfword data read drops ready for exactly one cycle, after which read data holds the first half of the word. A second-halfword data read completes with no wait state.
- R7: Select code 10 advances the address by one word, wrapping at the top of memory, after the second halfword of a data read or write. Select code 11 never changes the address. Select 00 is control and 01 is address.
- R8: A strobe given while ready is low is ignored.
- R9: While the address strobe is low, the select and halfword values used are those captured on its falling edge, not the live pins.
- R10: With the order bit 1 the first halfword is the upper half of the word, and with 0 it is the lower half, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_stb | input | 1 | One-cycle access strobe from the host |
| h_sel | input | 2 | Register select: 00 control, 01 address, 10 data with increment, 11 data |
| h_rnw | input | 1 | 1 for read, 0 for write |
| h_hw | input | 1 | 0 for the first halfword of a pair, 1 for the second |
| h_as_n | input | 1 | Active-low address strobe for multiplexed hosts; tie high if unused |
| h_wdata | input | 16 | Write halfword |
| h_rdata | output | 16 | Registered read halfword |
| h_rdy | output | 1 | Ready; low inserts host wait states |
| h_irq | output | 1 | Interrupt to the host |

## Verification
Control, address and second-half data reads are due one clock after the accepting edge. A first-half data read holds ready low for one cycle and returns its data on the edge after that. The memory write and the address increment take effect on the edge that accepts the second halfword. The bench drives a strobe at a falling edge and samples at the next falling edge. If ready is low there, it waits one more falling edge. This puts every sample half a cycle after the register that produces it. The wait-state tests check ready at that first falling edge, and the stall test puts its strobe exactly in the wait cycle.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_ADDR     = 2'b01,
    SEL_DATA_INC = 2'b10,
    SEL_DATA     = 2'b11
  } hsel_e;

  localparam int CTL_ORDER_BIT = 0;
  localparam int CTL_IRQ_BIT   = 1;
endpackage

// File: rtl/hpi_front.sv
module hpi_front
  import hpi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       as_n,
  input  logic [1:0] sel_pin,
  input  logic       hw_pin,
  output hsel_e      eff_sel,
  output logic       eff_hw
);
  logic       as_q;
  logic [1:0] lat_sel;
  logic       lat_hw;
  logic       fall;
  logic       use_lat;

  assign fall    = as_q && !as_n;
  assign use_lat = !as_n && !fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      as_q    <= 1'b1;
      lat_sel <= 2'b00;
      lat_hw  <= 1'b0;
    end else begin
      as_q <= as_n;
      if (fall) begin
        lat_sel <= sel_pin;
        lat_hw  <= hw_pin;
      end
    end
  end

  always_comb begin
    eff_sel = use_lat ? hsel_e'(lat_sel) : hsel_e'(sel_pin);
    eff_hw  = use_lat ? lat_hw : hw_pin;
  end
endmodule

// File: rtl/hpi_ram.sv
module hpi_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/hpi_regs.sv
module hpi_regs
  import hpi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  hsel_e             sel,
  input  logic              rnw,
  input  logic              hw,
  input  logic [DATA_W/2-1:0] wdata,
  input  logic [DATA_W-1:0] mem_q,
  output logic [DATA_W/2-1:0] rdata,
  output logic              rdy,
  output logic              irq,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wd
);
  localparam int HALF_W = DATA_W / 2;
  localparam int PAD_W  = HALF_W - ADDR_W;

  logic              order_q;
  logic [HALF_W-1:0] hold_q;
  logic [DATA_W-1:0] rbuf_q;
  logic              wait_q;
  logic              ms;
  logic              is_data;
  logic              inc;

  assign ms      = hw ^ order_q;
  assign is_data = (sel == SEL_DATA) || (sel == SEL_DATA_INC);
  assign inc     = (sel == SEL_DATA_INC);

  always_comb begin
    mem_we = acc && is_data && !rnw && hw;
    mem_wd = order_q ? {hold_q, wdata} : {wdata, hold_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      order_q <= 1'b0;
      irq     <= 1'b0;
      addr    <= '0;
      hold_q  <= '0;
      rbuf_q  <= '0;
      wait_q  <= 1'b0;
      rdy     <= 1'b1;
      rdata   <= '0;
    end else if (wait_q) begin
      rbuf_q <= mem_q;
      rdata  <= order_q ? mem_q[DATA_W-1:HALF_W] : mem_q[HALF_W-1:0];
      rdy    <= 1'b1;
      wait_q <= 1'b0;
    end else if (acc) begin
      unique case (sel)
        SEL_CTRL: begin
          if (rnw) begin
            rdata <= '0;
            rdata[CTL_ORDER_BIT] <= order_q;
            rdata[CTL_IRQ_BIT]   <= irq;
          end else if (!hw) begin
            order_q <= wdata[CTL_ORDER_BIT];
            if (wdata[CTL_IRQ_BIT]) irq <= ~irq;
          end
        end
        SEL_ADDR: begin
          if (rnw) rdata <= ms ? '0 : {{PAD_W{1'b0}}, addr};
          else if (!ms) addr <= wdata[ADDR_W-1:0];
        end
        default: begin
          if (rnw) begin
            if (!hw) begin
              wait_q <= 1'b1;
              rdy    <= 1'b0;
            end else begin
              rdata <= ms ? rbuf_q[DATA_W-1:HALF_W] : rbuf_q[HALF_W-1:0];
              if (inc) addr <= addr + 1'b1;
            end
          end else begin
            if (!hw) hold_q <= wdata;
            else if (inc) addr <= addr + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hpi_host_port.sv
module hpi_host_port
  import hpi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                h_stb,
  input  logic [1:0]          h_sel,
  input  logic                h_rnw,
  input  logic                h_hw,
  input  logic                h_as_n,
  input  logic [DATA_W/2-1:0] h_wdata,
  output logic [DATA_W/2-1:0] h_rdata,
  output logic                h_rdy,
  output logic                h_irq
);
  hsel_e             eff_sel;
  logic              eff_hw;
  logic              acc;
  logic [ADDR_W-1:0] addr_q;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wd;
  logic [DATA_W-1:0] mem_q;

  assign acc = h_stb && h_rdy;

  hpi_front u_front (
    .clk     (clk),
    .rst     (rst),
    .as_n    (h_as_n),
    .sel_pin (h_sel),
    .hw_pin  (h_hw),
    .eff_sel (eff_sel),
    .eff_hw  (eff_hw)
  );

  hpi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .acc    (acc),
    .sel    (eff_sel),
    .rnw    (h_rnw),
    .hw     (eff_hw),
    .wdata  (h_wdata),
    .mem_q  (mem_q),
    .rdata  (h_rdata),
    .rdy    (h_rdy),
    .irq    (h_irq),
    .addr   (addr_q),
    .mem_we (mem_we),
    .mem_wd (mem_wd)
  );

  hpi_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .addr  (addr_q),
    .wdata (mem_wd),
    .rdata (mem_q)
  );
endmodule

// File: rtl/hpi_checker.sv
module hpi_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              h_stb,
  input logic              h_rdy,
  input logic              h_irq,
  input logic              h_rnw,
  input logic [1:0]        eff_sel,
  input logic              eff_hw,
  input logic [ADDR_W-1:0] addr_q,
  input logic              mem_we
);
  logic taken;
  assign taken = h_stb && h_rdy;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (h_rdy && !h_irq));

  assert_irq_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(taken && eff_sel == 2'b00 && !h_rnw) |=> $stable(h_irq));

  assert_wr_second_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (eff_hw && !h_rnw && taken));

  assert_rd_wait_R6: assert property (@(posedge clk) disable iff (rst)
    (taken && eff_sel[1] && h_rnw && !eff_hw) |=> !h_rdy);

  assert_rdy_back_R6: assert property (@(posedge clk) disable iff (rst)
    !h_rdy |=> h_rdy);

  assert_no_inc_R7: assert property (@(posedge clk) disable iff (rst)
    (taken && eff_sel == 2'b11) |=> $stable(addr_q));

  assert_stall_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    !h_rdy |=> $stable(addr_q));
endmodule

bind hpi_host_port hpi_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .h_stb   (h_stb),
  .h_rdy   (h_rdy),
  .h_irq   (h_irq),
  .h_rnw   (h_rnw),
  .eff_sel (eff_sel),
  .eff_hw  (eff_hw),
  .addr_q  (addr_q),
  .mem_we  (mem_we)
);

// File: tb/tb_hpi_host_port.sv
`timescale 1ns/1ps
module tb_hpi_host_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_stb = 1'b0;
  logic [1:0]  h_sel = 2'b00;
  logic        h_rnw = 1'b0;
  logic        h_hw = 1'b0;
  logic        h_as_n = 1'b1;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata;
  logic        h_rdy;
  logic        h_irq;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;
  bit  ord = 0;

  always #2 clk = ~clk;

  hpi_host_port dut (
    .clk(clk), .rst(rst), .h_stb(h_stb), .h_sel(h_sel), .h_rnw(h_rnw),
    .h_hw(h_hw), .h_as_n(h_as_n), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .h_rdy(h_rdy), .h_irq(h_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] s, input logic rnw, input logic hw,
                     input logic [15:0] d, output logic [15:0] r, output logic wt);
    @(negedge clk);
    h_sel = s; h_rnw = rnw; h_hw = hw; h_wdata = d; h_stb = 1'b1;
    @(negedge clk);
    h_stb = 1'b0;
    wt = !h_rdy;
    if (wt) @(negedge clk);
    r = h_rdata;
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    logic [15:0] r; logic wt;
    cyc(2'b00, 1'b0, 1'b0, v, r, wt);
    cyc(2'b00, 1'b0, 1'b1, v ^ 16'h0002, r, wt);
    ord = v[0];
  endtask

  task automatic rd_ctl(output logic [15:0] r);
    logic wt;
    cyc(2'b00, 1'b1, 1'b0, 16'h0, r, wt);
  endtask

  task automatic wr_addr(input logic [9:0] a);
    logic [15:0] r; logic wt;
    cyc(2'b01, 1'b0, 1'b0, ord ? 16'h0 : {6'h0, a}, r, wt);
    cyc(2'b01, 1'b0, 1'b1, ord ? {6'h0, a} : 16'h0, r, wt);
  endtask

  task automatic rd_addr(output logic [15:0] lo, output logic [15:0] hi);
    logic [15:0] a, b; logic wt;
    cyc(2'b01, 1'b1, 1'b0, 16'h0, a, wt);
    cyc(2'b01, 1'b1, 1'b1, 16'h0, b, wt);
    lo = ord ? b : a;
    hi = ord ? a : b;
  endtask

  task automatic wr_word(input logic [1:0] s, input logic [31:0] w);
    logic [15:0] r; logic wt;
    cyc(s, 1'b0, 1'b0, ord ? w[31:16] : w[15:0], r, wt);
    cyc(s, 1'b0, 1'b1, ord ? w[15:0] : w[31:16], r, wt);
  endtask

  task automatic rd_word(input logic [1:0] s, output logic [31:0] w);
    logic [15:0] a, b; logic wt;
    cyc(s, 1'b1, 1'b0, 16'h0, a, wt);
    cyc(s, 1'b1, 1'b1, 16'h0, b, wt);
    w = ord ? {a, b} : {b, a};
  endtask

  task automatic t_reset;
    logic [15:0] r;
    chk("R1 rdy", {31'h0, h_rdy}, 32'h1);
    chk("R1 irq", {31'h0, h_irq}, 32'h0);
    chk("R1 rdata", {16'h0, h_rdata}, 32'h0);
    rd_ctl(r);
    chk("R1 ctl", {16'h0, r}, 32'h0);
  endtask

  task automatic t_ctrl;
    logic [15:0] r;
    wr_ctl(16'h0001);
    rd_ctl(r);
    chk("R2 order", {16'h0, r}, 32'h1);
    wr_ctl(16'h0003);
    chk("R3 set", {31'h0, h_irq}, 32'h1);
    wr_ctl(16'h0001);
    chk("R3 hold", {31'h0, h_irq}, 32'h1);
    rd_ctl(r);
    chk("R2 rd irq", {16'h0, r}, 32'h3);
    wr_ctl(16'h0002);
    chk("R3 clr", {31'h0, h_irq}, 32'h0);
    rd_ctl(r);
    chk("R2 order0", {16'h0, r}, 32'h0);
  endtask

  task automatic t_addr;
    logic [15:0] lo, hi;
    wr_addr(10'h155);
    rd_addr(lo, hi);
    chk("R4 lo", {16'h0, lo}, 32'h155);
    chk("R4 hi", {16'h0, hi}, 32'h0);
    wr_ctl(16'h0001);
    wr_addr(10'h2AA);
    rd_addr(lo, hi);
    chk("R4 lo ord1", {16'h0, lo}, 32'h2AA);
    chk("R4 hi ord1", {16'h0, hi}, 32'h0);
    wr_ctl(16'h0000);
  endtask

  task automatic t_order;
    logic [31:0] w; logic [15:0] r, lo, hi; logic wt;
    wr_addr(10'd5);
    wr_word(2'b11, 32'hDEADBEEF);
    rd_word(2'b11, w);
    chk("R10 ord0 word", w, 32'hDEADBEEF);
    rd_addr(lo, hi);
    chk("R7 no inc", {16'h0, lo}, 32'd5);
    wr_ctl(16'h0001);
    wr_addr(10'd6);
    wr_word(2'b11, 32'h12345678);
    cyc(2'b11, 1'b1, 1'b0, 16'h0, r, wt);
    chk("R10 first=upper", {16'h0, r}, 32'h1234);
    cyc(2'b11, 1'b1, 1'b1, 16'h0, r, wt);
    chk("R10 second=lower", {16'h0, r}, 32'h5678);
    wr_ctl(16'h0000);
    cyc(2'b11, 1'b1, 1'b0, 16'h0, r, wt);
    chk("R10 first=lower", {16'h0, r}, 32'h5678);
    cyc(2'b11, 1'b1, 1'b1, 16'h0, r, wt);
  endtask

  task automatic t_inc;
    logic [31:0] w; logic [15:0] lo, hi;
    wr_addr(10'h3FE);
    wr_word(2'b10, 32'hA0A0_0001);
    wr_word(2'b10, 32'hB0B0_0002);
    wr_word(2'b10, 32'hC0C0_0003);
    rd_addr(lo, hi);
    chk("R7 wrap", {16'h0, lo}, 32'h1);
    wr_addr(10'h3FE);
    rd_word(2'b10, w);
    chk("R7 rd0", w, 32'hA0A0_0001);
    rd_word(2'b10, w);
    chk("R7 rd1", w, 32'hB0B0_0002);
    rd_word(2'b10, w);
    chk("R7 rd2", w, 32'hC0C0_0003);
    rd_addr(lo, hi);
    chk("R7 rd inc", {16'h0, lo}, 32'h1);
  endtask

  task automatic t_pending;
    logic [31:0] w; logic [15:0] r; logic wt;
    wr_addr(10'd8);
    wr_word(2'b11, 32'h1111_2222);
    cyc(2'b11, 1'b0, 1'b0, 16'h9999, r, wt);
    rd_word(2'b11, w);
    chk("R5 unchanged", w, 32'h1111_2222);
    cyc(2'b11, 1'b0, 1'b1, 16'h7777, r, wt);
    rd_word(2'b11, w);
    chk("R5 written", w, 32'h7777_9999);
  endtask

  task automatic t_wait;
    logic [15:0] r, lo, hi; logic wt;
    cyc(2'b11, 1'b1, 1'b0, 16'h0, r, wt);
    chk("R6 wait first", {31'h0, wt}, 32'h1);
    chk("R6 data first", {16'h0, r}, 32'h9999);
    cyc(2'b11, 1'b1, 1'b1, 16'h0, r, wt);
    chk("R6 no wait second", {31'h0, wt}, 32'h0);
    chk("R6 data second", {16'h0, r}, 32'h7777);
    @(negedge clk);
    h_sel = 2'b11; h_rnw = 1'b1; h_hw = 1'b0; h_stb = 1'b1;
    @(negedge clk);
    chk("R6 rdy low", {31'h0, h_rdy}, 32'h0);
    h_sel = 2'b01; h_rnw = 1'b0; h_hw = 1'b0; h_wdata = 16'h03FF;
    @(negedge clk);
    h_stb = 1'b0;
    chk("R6 rdy back", {31'h0, h_rdy}, 32'h1);
    cyc(2'b11, 1'b1, 1'b1, 16'h0, r, wt);
    rd_addr(lo, hi);
    chk("R8 ignored", {16'h0, lo}, 32'd8);
  endtask

  task automatic t_as;
    logic [15:0] r, lo, hi; logic wt;
    @(negedge clk);
    h_as_n = 1'b0; h_sel = 2'b11; h_hw = 1'b0; h_rnw = 1'b1;
    @(negedge clk);
    h_sel = 2'b01; h_hw = 1'b1; h_stb = 1'b1;
    @(negedge clk);
    h_stb = 1'b0;
    chk("R9 latched wait", {31'h0, !h_rdy}, 32'h1);
    @(negedge clk);
    chk("R9 latched data", {16'h0, h_rdata}, 32'h9999);
    h_as_n = 1'b1;
    cyc(2'b11, 1'b1, 1'b1, 16'h0, r, wt);
    chk("R9 second", {16'h0, r}, 32'h7777);
    rd_addr(lo, hi);
    chk("R9 addr kept", {16'h0, lo}, 32'd8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_addr();
    t_order();
    t_inc();
    t_pending();
    t_wait();
    t_as();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule